// File: doc/BRIEF.md
# Phase-Lock Detector with Alarm

This block watches a divide-by-N feedback strobe against a fixed reference strobe and decides, once per reference period, whether the loop is in phase. Both strobes last one clock and are already synchronous to the system clock. A feedback strobe that lands within WIN clocks on either side of a reference strobe counts as in phase. A strobe that lands later, up to LATE_MAX clocks after the reference, counts as late. A strobe that lands after that late zone, and more than WIN clocks before the next reference, counts as early for that next reference. A period with none of these counts as missing. Each verdict is published as a two-bit correction code for a downstream phase-error stage. A non-zero code is the error indication.

The same verdicts drive a lock state machine with three states. In SEARCH, LOCK_CNT consecutive in-phase verdicts take the transition ACQUIRE to LOCKED, and any other verdict takes RESTART, which clears the run count. In LOCKED, a bad verdict takes the transition SLIP to SLIPPING. In SLIPPING, an in-phase verdict takes RECOVER back to LOCKED, and LOSE_CNT consecutive bad verdicts take DROP to SEARCH. The lock indicator is high in LOCKED and SLIPPING. The failure lamp is high in SEARCH or while a test request is present.

Top module: `phase_lock_alarm`

## Requirements
- R1: A feedback strobe that arrives from WIN clocks before to WIN clocks after a reference strobe gives corr = 00 for that period. This includes a strobe in the same cycle as the reference. This verdict takes priority over every other verdict in that period.
- R2: With no in-phase strobe, a feedback strobe that arrives between WIN+1 and LATE_MAX clocks after the reference gives corr = 01.
- R3: With no in-phase strobe, a feedback strobe that arrives after the previous reference's late zone and more than WIN clocks before the reference gives corr = 10. This holds even when no feedback strobe follows that reference.
- R4: A period with no feedback strobe in its early, in-phase or late zones gives corr = 11.
- R5: corr changes only in the clock edge LATE_MAX cycles after a reference strobe. At all other times it holds its value.
- R6: From SEARCH, lock_ok rises with the verdict that completes LOCK_CNT consecutive corr = 00 periods, and not earlier.
- R7: While locked, one bad period keeps lock_ok high (state SLIPPING), and a following 00 period returns to LOCKED. LOSE_CNT consecutive bad periods drop lock_ok.
- R8: With test_req low in the previous cycle, fail_lamp equals the inverse of lock_ok.
- R9: A test_req sampled high forces fail_lamp high in the next cycle. It leaves lock_ok unchanged.
- R10: Synchronous reset gives lock_ok = 0, fail_lamp = 1, corr = 00 and state SEARCH with a cleared run count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | One-clock reference strobe |
| fb_pulse | input | 1 | One-clock divide-by-N feedback strobe |
| test_req | input | 1 | Lamp test request, forces the failure lamp on |
| lock_ok | output | 1 | High while the loop is judged locked |
| fail_lamp | output | 1 | Failure indicator |
| corr | output | 2 | Correction code: 00 in phase, 01 late, 10 early, 11 missing |

## Verification
The checks assume single-clock strobes and a reference period longer than LATE_MAX + WIN + 1 clocks, so that the verdict for one reference is made before the next reference arrives. The stimulus keeps to this with a 40-clock frame that holds exactly one reference strobe and at most one feedback strobe. Frame position 20 is the reference. The feedback offsets run from -20 to +11. Test requests are applied only between frames, when no verdict can occur, so any lock_ok change seen then would be a fault.

// File: rtl/pld_pkg.sv
package pld_pkg;

    typedef enum logic [1:0] {
        CORR_INPHASE = 2'b00,
        CORR_LATE    = 2'b01,
        CORR_EARLY   = 2'b10,
        CORR_MISSING = 2'b11
    } corr_e;

    typedef enum logic [1:0] {
        LK_SEARCH   = 2'b00,
        LK_LOCKED   = 2'b01,
        LK_SLIPPING = 2'b10
    } lock_state_e;

endpackage

// File: rtl/pld_phase_window.sv
module pld_phase_window
    import pld_pkg::*;
#(
    parameter int WIN      = 2,
    parameter int LATE_MAX = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_pulse,
    input  logic  fb_pulse,
    output logic  verdict_vld,
    output corr_e verdict
);

    localparam int CW = $clog2(LATE_MAX + 2);
    localparam logic [CW-1:0] C_SAT  = CW'(LATE_MAX + 1);
    localparam logic [CW-1:0] C_WIN  = CW'(WIN);
    localparam logic [CW-1:0] C_LATE = CW'(LATE_MAX);

    logic [CW-1:0] since_ref_q;
    logic [CW-1:0] since_fb_q;
    logic          hit_q;
    logic          late_q;
    logic          early_q;
    logic          pend_early_q;

    logic fb_in_win;
    logic fb_late;
    logic fb_early_zone;
    logic pre_hit;
    logic decide;
    logic hit_now;
    logic late_now;

    always_comb begin
        fb_in_win     = fb_pulse && !ref_pulse && (since_ref_q <= C_WIN);
        fb_late       = fb_pulse && !ref_pulse && (since_ref_q > C_WIN) &&
                        (since_ref_q <= C_LATE);
        fb_early_zone = fb_pulse && !ref_pulse && (since_ref_q > C_LATE);
        pre_hit       = ref_pulse && (fb_pulse || (since_fb_q < C_WIN));
        decide        = !ref_pulse && (since_ref_q == C_LATE);
        hit_now       = hit_q || fb_in_win;
        late_now      = late_q || fb_late;
    end

    always_comb begin
        verdict_vld = decide;
        if (hit_now) begin
            verdict = CORR_INPHASE;
        end else if (early_q) begin
            verdict = CORR_EARLY;
        end else if (late_now) begin
            verdict = CORR_LATE;
        end else begin
            verdict = CORR_MISSING;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_ref_q <= C_SAT;
            since_fb_q  <= C_SAT;
        end else begin
            if (ref_pulse) begin
                since_ref_q <= CW'(1);
            end else if (since_ref_q != C_SAT) begin
                since_ref_q <= since_ref_q + 1'b1;
            end
            if (fb_pulse) begin
                since_fb_q <= '0;
            end else if (since_fb_q != C_SAT) begin
                since_fb_q <= since_fb_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q        <= 1'b0;
            late_q       <= 1'b0;
            early_q      <= 1'b0;
            pend_early_q <= 1'b0;
        end else begin
            if (ref_pulse) begin
                pend_early_q <= 1'b0;
            end else if (fb_early_zone) begin
                pend_early_q <= 1'b1;
            end

            if (ref_pulse) begin
                hit_q   <= pre_hit;
                early_q <= pend_early_q && !pre_hit;
                late_q  <= 1'b0;
            end else if (decide) begin
                hit_q   <= 1'b0;
                early_q <= 1'b0;
                late_q  <= 1'b0;
            end else begin
                if (fb_in_win) begin
                    hit_q <= 1'b1;
                end
                if (fb_late) begin
                    late_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
    import pld_pkg::*;
#(
    parameter int LOCK_CNT = 4,
    parameter int LOSE_CNT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       verdict_vld,
    input  corr_e      verdict,
    input  logic       test_req,
    output logic       lock_ok,
    output logic       fail_lamp,
    output logic [1:0] corr
);

    localparam int RMAX = (LOCK_CNT > LOSE_CNT) ? LOCK_CNT : LOSE_CNT;
    localparam int RW   = $clog2(RMAX + 1);
    localparam logic [RW-1:0] R_LOCK = RW'(LOCK_CNT);
    localparam logic [RW-1:0] R_LOSE = RW'(LOSE_CNT);

    lock_state_e   state_q, state_d;
    logic [RW-1:0] run_q, run_d;
    logic [RW-1:0] run_inc;
    logic          good;

    always_comb begin
        run_inc = run_q + 1'b1;
        good    = (verdict == CORR_INPHASE);
        state_d = state_q;
        run_d   = run_q;
        if (verdict_vld) begin
            unique case (state_q)
                LK_SEARCH: begin
                    if (!good) begin
                        run_d = '0;
                    end else if (run_inc == R_LOCK) begin
                        state_d = LK_LOCKED;
                        run_d   = '0;
                    end else begin
                        run_d = run_inc;
                    end
                end
                LK_LOCKED: begin
                    if (!good) begin
                        if (R_LOSE == RW'(1)) begin
                            state_d = LK_SEARCH;
                            run_d   = '0;
                        end else begin
                            state_d = LK_SLIPPING;
                            run_d   = RW'(1);
                        end
                    end
                end
                LK_SLIPPING: begin
                    if (good) begin
                        state_d = LK_LOCKED;
                        run_d   = '0;
                    end else if (run_inc == R_LOSE) begin
                        state_d = LK_SEARCH;
                        run_d   = '0;
                    end else begin
                        run_d = run_inc;
                    end
                end
                default: begin
                    state_d = LK_SEARCH;
                    run_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_SEARCH;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_ok   <= 1'b0;
            fail_lamp <= 1'b1;
            corr      <= 2'b00;
        end else begin
            lock_ok   <= (state_d != LK_SEARCH);
            fail_lamp <= test_req || (state_d == LK_SEARCH);
            if (verdict_vld) begin
                corr <= verdict;
            end
        end
    end

endmodule

// File: rtl/phase_lock_alarm.sv
module phase_lock_alarm
    import pld_pkg::*;
#(
    parameter int WIN      = 2,
    parameter int LATE_MAX = 10,
    parameter int LOCK_CNT = 4,
    parameter int LOSE_CNT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_pulse,
    input  logic       fb_pulse,
    input  logic       test_req,
    output logic       lock_ok,
    output logic       fail_lamp,
    output logic [1:0] corr
);

    logic  verdict_vld;
    corr_e verdict;

    pld_phase_window #(
        .WIN      (WIN),
        .LATE_MAX (LATE_MAX)
    ) u_window (
        .clk         (clk),
        .rst         (rst),
        .ref_pulse   (ref_pulse),
        .fb_pulse    (fb_pulse),
        .verdict_vld (verdict_vld),
        .verdict     (verdict)
    );

    pld_lock_fsm #(
        .LOCK_CNT (LOCK_CNT),
        .LOSE_CNT (LOSE_CNT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .verdict_vld (verdict_vld),
        .verdict     (verdict),
        .test_req    (test_req),
        .lock_ok     (lock_ok),
        .fail_lamp   (fail_lamp),
        .corr        (corr)
    );

endmodule

// File: rtl/pld_chk.sv
module pld_chk (
    input logic       clk,
    input logic       rst,
    input logic       test_req,
    input logic       lock_ok,
    input logic       fail_lamp,
    input logic [1:0] corr,
    input logic       verdict_vld
);

    // R9
    test_forces_fail_chk: assert property (@(posedge clk) disable iff (rst)
        test_req |=> fail_lamp);

    // R9
    test_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (test_req && !verdict_vld) |=> (lock_ok == $past(lock_ok)));

    // R5
    corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !verdict_vld |=> $stable(corr));

    // R6
    lock_on_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_ok) |-> (corr == 2'b00));

    // R7
    unlock_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_ok) |-> (corr != 2'b00));

    // R8
    lamp_follows_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(test_req) |-> (fail_lamp == !lock_ok));

endmodule

bind phase_lock_alarm pld_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .test_req    (test_req),
    .lock_ok     (lock_ok),
    .fail_lamp   (fail_lamp),
    .corr        (corr),
    .verdict_vld (verdict_vld)
);

// File: tb/sim_phase_lock_alarm.sv
module sim_phase_lock_alarm;

    localparam int NONE  = 99;
    localparam int FRAME = 40;
    localparam int REFAT = 20;
    localparam int NVEC  = 17;

    // columns: feedback offset, expected corr, expected lock_ok, expected fail_lamp
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{  0, 0, 0, 1},
        '{  1, 0, 0, 1},
        '{ -2, 0, 0, 1},
        '{  2, 0, 1, 0},
        '{  3, 1, 1, 0},
        '{  0, 0, 1, 0},
        '{ -3, 2, 1, 0},
        '{NONE, 3, 0, 1},
        '{ 10, 1, 0, 1},
        '{ 11, 3, 0, 1},
        '{NONE, 2, 0, 1},
        '{  0, 0, 0, 1},
        '{  0, 0, 0, 1},
        '{  0, 0, 0, 1},
        '{  0, 0, 1, 0},
        '{-20, 2, 1, 0},
        '{  5, 1, 0, 1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0;
    logic       fb_pulse = 1'b0;
    logic       test_req = 1'b0;
    logic       lock_ok;
    logic       fail_lamp;
    logic [1:0] corr;

    int total = 0;
    int bad = 0;
    int last_corr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    phase_lock_alarm u0 (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .test_req  (test_req),
        .lock_ok   (lock_ok),
        .fail_lamp (fail_lamp),
        .corr      (corr)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string corr_req(input int code);
        case (code)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_frame(input int off);
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            ref_pulse = (i == REFAT);
            fb_pulse  = (off != NONE) && (i == REFAT + off);
            if (i == REFAT + 5) begin
                // R5: before the verdict edge the code still holds the previous value
                chk("R5", int'(corr), last_corr);
            end
        end
        @(negedge clk);
        ref_pulse = 1'b0;
        fb_pulse  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", int'(lock_ok), 0);
        chk("R10", int'(fail_lamp), 1);
        chk("R10", int'(corr), 0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][0]);
            chk(corr_req(VEC[v][1]), int'(corr), VEC[v][1]);
            chk((VEC[v][2] != 0) ? "R6" : "R7", int'(lock_ok), VEC[v][2]);
            chk("R8", int'(fail_lamp), VEC[v][3]);
            last_corr = VEC[v][1];
        end

        // R6: three in-phase periods are not enough, the fourth locks
        for (int k = 0; k < 4; k++) begin
            run_frame(0);
            last_corr = 0;
            chk("R6", int'(lock_ok), (k == 3) ? 1 : 0);
        end

        // R9: lamp test while locked
        @(negedge clk);
        test_req = 1'b1;
        @(negedge clk);
        chk("R9", int'(fail_lamp), 1);
        chk("R9", int'(lock_ok), 1);
        @(negedge clk);
        test_req = 1'b0;
        chk("R9", int'(lock_ok), 1);
        @(negedge clk);
        chk("R8", int'(fail_lamp), 0);

        // R10: reset while locked
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", int'(lock_ok), 0);
        chk("R10", int'(fail_lamp), 1);
        chk("R10", int'(corr), 0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule